// File: doc/BRIEF.md
# Sigmoid Neuron Activation Unit

This block turns the accumulated, signed weighted sum of one neuron into that neuron's output value through an S-shaped curve. The curve is set entirely by parameters: its slope at the origin, its upper limit and its lower limit. With span R = upper − lower, the continuous form is f(x) = lower + R / (1 + exp(−4·slope·x / R)). This gives the requested slope at x = 0, and the curve tends to the upper limit for large positive x and to the lower limit for large negative x.

The incoming sum is wider than the activation code. It is first saturated to the symmetric range of the activation code. The saturated code then indexes a table that is computed from the parameters when the design is elaborated. The registered table word is the neuron output.

Each quantised set of values has a bit count n and a full-scale magnitude M. A code d stands for the continuous value d·M/(2^(n−1)−1). The activation input and the output each have their own n and M. The output uses the same width as the network inputs, so it can feed the next layer directly.

Top module: `sig_act_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` = 0 and `y_out` = 0.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge.
- R3: For an accepted sample with a sum code d where |d| ≤ 2^(ACT_W−1)−1, `y_out` one cycle later equals round(f(d·ACT_RANGE/(2^(ACT_W−1)−1)) · (2^(OUT_W−1)−1)/OUT_RANGE). Rounding is to the nearest code, with halves away from zero. The result is held within ±(2^(OUT_W−1)−1).
- R4: A sum above +(2^(ACT_W−1)−1) produces the same output as the sum +(2^(ACT_W−1)−1).
- R5: A sum below −(2^(ACT_W−1)−1) produces the same output as the sum −(2^(ACT_W−1)−1). This includes the most negative activation code −2^(ACT_W−1).
- R6: For two samples accepted in consecutive cycles, a larger or equal second sum never gives a smaller signed output.
- R7: A cycle with `in_valid` low leaves `y_out` unchanged, whatever `sum_in` carries.
- R8: A zero sum gives the output code of the curve midpoint (lower + upper)/2. With the default limits ±1, this is code 0.
- R9: `y_out`, read as signed, always lies between the quantised codes of the lower limit and the upper limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `sum_in` as a sample to convert |
| sum_in | input | SUM_W | Signed weighted sum, in activation-code units |
| out_valid | output | 1 | Marks `y_out` as freshly converted |
| y_out | output | OUT_W | Signed neuron output code |

## Verification
The bench sweeps every in-range activation code and compares each output with the curve, which it evaluates in floating point. A table entry built with the wrong offset or the wrong scale would show up as a mismatch at almost every code. It drives sums far past both rails and the single most negative activation code. A design that let the low bits wrap instead of saturating would produce outputs that jump from one rail to the other. It also checks that outputs never decrease across the sweep, that a zero sum lands on the midpoint, and that idle cycles with a changing sum leave the output frozen. A design that latched data without qualification would fail that last check.

// File: rtl/sig_pkg.sv
package sig_pkg;

    // Rounds a continuous value to the nearest code for an n-bit set with
    // full scale rng, halves away from zero, clamped to the symmetric range.
    function automatic int quantise(input real v, input real rng, input int w);
        real q;
        int  lim;
        int  r;
        lim = (1 << (w - 1)) - 1;
        q   = v * real'(lim) / rng;
        if (q >= 0.0) r = int'($floor(q + 0.5));
        else          r = -int'($floor(-q + 0.5));
        if (r > lim)  r = lim;
        if (r < -lim) r = -lim;
        return r;
    endfunction

    // Output code of the curve for activation code d.
    function automatic int curve_code(
        input int  d,
        input int  act_w,
        input int  out_w,
        input real act_rng,
        input real out_rng,
        input real slope0,
        input real f_hi,
        input real f_lo
    );
        real span;
        real x;
        real f;
        span = f_hi - f_lo;
        x    = real'(d) * act_rng / real'((1 << (act_w - 1)) - 1);
        f    = f_lo + span / (1.0 + $exp(-4.0 * slope0 * x / span));
        return quantise(f, out_rng, out_w);
    endfunction

endpackage

// File: rtl/sig_clip.sv
module sig_clip #(
    parameter int SUM_W = 12,
    parameter int ACT_W = 8
) (
    input  logic signed [SUM_W-1:0] sum_in,
    output logic signed [ACT_W-1:0] act_code
);
    localparam int LIM = (1 << (ACT_W - 1)) - 1;
    localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'(LIM);
    localparam logic signed [SUM_W-1:0] NEG_LIM = -POS_LIM;

    always_comb begin
        if (sum_in > POS_LIM)      act_code = ACT_W'(LIM);
        else if (sum_in < NEG_LIM) act_code = -ACT_W'(LIM);
        else                       act_code = sum_in[ACT_W-1:0];
    end
endmodule

// File: rtl/sig_rom.sv
module sig_rom #(
    parameter int  ACT_W     = 8,
    parameter int  OUT_W     = 8,
    parameter real ACT_RANGE = 4.0,
    parameter real OUT_RANGE = 1.0,
    parameter real SLOPE0    = 0.5,
    parameter real F_MAX     = 1.0,
    parameter real F_MIN     = -1.0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic signed [ACT_W-1:0] act_code,
    output logic        [OUT_W-1:0] word_q
);
    localparam int DEPTH = 1 << ACT_W;
    localparam int HALF  = DEPTH / 2;

    logic [OUT_W-1:0] table_w [DEPTH];
    logic [ACT_W-1:0] idx;

    // offset-binary index: code -HALF sits at entry 0
    assign idx = {~act_code[ACT_W-1], act_code[ACT_W-2:0]};

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int CODE = sig_pkg::curve_code(i - HALF, ACT_W, OUT_W,
                                                  ACT_RANGE, OUT_RANGE,
                                                  SLOPE0, F_MAX, F_MIN);
        assign table_w[i] = OUT_W'(CODE);
    end

    always_ff @(posedge clk) begin
        if (rst)        word_q <= '0;
        else if (rd_en) word_q <= table_w[idx];
    end
endmodule

// File: rtl/sig_act_unit.sv
module sig_act_unit #(
    parameter int  SUM_W     = 12,
    parameter int  ACT_W     = 8,
    parameter int  OUT_W     = 8,
    parameter real ACT_RANGE = 4.0,
    parameter real OUT_RANGE = 1.0,
    parameter real SLOPE0    = 0.5,
    parameter real F_MAX     = 1.0,
    parameter real F_MIN     = -1.0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SUM_W-1:0] sum_in,
    output logic             out_valid,
    output logic [OUT_W-1:0] y_out
);
    localparam int HI_CODE = sig_pkg::quantise(F_MAX, OUT_RANGE, OUT_W);
    localparam int LO_CODE = sig_pkg::quantise(F_MIN, OUT_RANGE, OUT_W);

    logic signed [ACT_W-1:0] act_code;

    sig_clip #(.SUM_W(SUM_W), .ACT_W(ACT_W)) u_clip (
        .sum_in   ($signed(sum_in)),
        .act_code (act_code)
    );

    sig_rom #(
        .ACT_W(ACT_W), .OUT_W(OUT_W), .ACT_RANGE(ACT_RANGE),
        .OUT_RANGE(OUT_RANGE), .SLOPE0(SLOPE0), .F_MAX(F_MAX), .F_MIN(F_MIN)
    ) u_rom (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (in_valid),
        .act_code (act_code),
        .word_q   (y_out)
    );

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && y_out == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(y_out));

    // R6
    monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $past(in_valid) && !$past(rst)
         && $signed(sum_in) >= $signed($past(sum_in)))
        |=> $signed(y_out) >= $signed($past(y_out)));

    // R9
    output_range_chk: assert property (@(posedge clk) disable iff (rst)
        ($signed(y_out) <= HI_CODE) && ($signed(y_out) >= LO_CODE));
endmodule

// File: tb/test_sig_act_unit.sv
module test_sig_act_unit;
    localparam int  SUM_W = 12;
    localparam int  ACT_W = 8;
    localparam int  OUT_W = 8;
    localparam int  LIM   = (1 << (ACT_W - 1)) - 1;
    localparam int  OLIM  = (1 << (OUT_W - 1)) - 1;
    localparam real A_RNG = 4.0;
    localparam real O_RNG = 1.0;
    localparam real SLP   = 0.5;
    localparam real FHI   = 1.0;
    localparam real FLO   = -1.0;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [SUM_W-1:0] sum_in = '0;
    logic             out_valid;
    logic [OUT_W-1:0] y_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sig_act_unit i_sig_act_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sum_in(sum_in),
        .out_valid(out_valid), .y_out(y_out)
    );

    function automatic int round_code(input real v);
        real q;
        int  r;
        q = v * real'(OLIM) / O_RNG;
        if (q >= 0.0) r = int'($floor(q + 0.5));
        else          r = -int'($floor(-q + 0.5));
        if (r > OLIM)  r = OLIM;
        if (r < -OLIM) r = -OLIM;
        return r;
    endfunction

    function automatic int expect_code(input int v);
        int  d;
        real x;
        real span;
        d = v;
        if (d > LIM)  d = LIM;
        if (d < -LIM) d = -LIM;
        span = FHI - FLO;
        x = real'(d) * A_RNG / real'(LIM);
        return round_code(FLO + span / (1.0 + $exp(-4.0 * SLP * x / span)));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic apply(input int v, output int got, output bit vld);
        sum_in   = SUM_W'(v);
        in_valid = 1'b1;
        @(negedge clk);
        got = int'($signed(y_out));
        vld = out_valid;
    endtask

    initial begin
        int got;
        bit vld;
        int prev;
        int ref_hi;
        int ref_lo;
        int held;
        repeat (3) @(negedge clk);
        // R1
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(y_out == '0, "R1", int'($signed(y_out)), 0);
        rst = 1'b0;
        @(negedge clk);
        // R2: idle gives no valid
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);

        // R3 / R6 / R9: full in-range sweep, including the most negative code
        prev = -OLIM - 1;
        for (int v = -LIM - 1; v <= LIM; v++) begin
            apply(v, got, vld);
            check(vld, "R2", int'(vld), 1);
            check(got == expect_code(v), (v < -LIM) ? "R5" : "R3", got, expect_code(v));
            check(got >= prev, "R6", got, prev);
            check(got <= round_code(FHI) && got >= round_code(FLO), "R9", got, round_code(FHI));
            prev = got;
        end

        // R8
        apply(0, got, vld);
        check(got == round_code((FHI + FLO) / 2.0), "R8", got, round_code((FHI + FLO) / 2.0));

        // R4: above the positive rail
        apply(LIM, ref_hi, vld);
        for (int v = LIM + 1; v < (1 << (SUM_W - 1)); v += 97) begin
            apply(v, got, vld);
            check(got == ref_hi, "R4", got, ref_hi);
        end
        apply((1 << (SUM_W - 1)) - 1, got, vld);
        check(got == ref_hi, "R4", got, ref_hi);

        // R5: below the negative rail
        apply(-LIM, ref_lo, vld);
        for (int v = -LIM - 1; v >= -(1 << (SUM_W - 1)); v -= 101) begin
            apply(v, got, vld);
            check(got == ref_lo, "R5", got, ref_lo);
        end
        apply(-(1 << (SUM_W - 1)), got, vld);
        check(got == ref_lo, "R5", got, ref_lo);

        // R7: idle cycles with a changing sum leave the output alone
        apply(40, held, vld);
        in_valid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            sum_in = SUM_W'(-300 + k * 150);
            @(negedge clk);
            check(int'($signed(y_out)) == held, "R7", int'($signed(y_out)), held);
            check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        end

        // R1 again after activity
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && y_out == '0, "R1", int'($signed(y_out)), 0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule